// File: doc/BRIEF.md
# Word and Byte Memory Port Controller

This block sits between the datapath registers and main memory and gives them two independent routes. The data route reads or writes whole 32-bit words. The word address it is given is turned into a byte address before it reaches memory, and read data returns into the memory data register. The fetch route reads single bytes of the program stream at a byte address and returns them into the fetch byte register. The fetch route never writes.

Each request comes from control bits in the current microinstruction. The address is presented in the cycle of the request. The synchronous memory answers on the next edge, and the result is captured into its register on the edge after that. The microinstruction two cycles after the request can therefore use it. A new request may be issued while an earlier one is still in flight, and results come back in request order.

The fetched byte reaches the B bus widened to a full word. A control input picks whether it is widened as a signed or an unsigned value. A read and a write requested together form an illegal combination: the block raises a flag and sends neither request to memory.

Top module: `mem_port_ctrl`

## Requirements
- R1: While rst_n is low, and after it is released until the first result arrives, mdr, mbr, mdr_valid, mbr_valid and mbr_bus are all zero.
- R2: With rd_req=1 and wr_req=0, dmem_rd is 1 in the same cycle and dmem_addr equals {mar, 2'b00}: the word address times four, with the two low bits zero.
- R3: With wr_req=1 and rd_req=0, dmem_wr is 1 in the same cycle, dmem_addr equals {mar, 2'b00}, and dmem_wdata equals wr_data. A write never changes mdr.
- R4: A read issued in cycle t loads the addressed word into mdr on the edge that ends cycle t+1. mdr_valid is 1 for exactly cycle t+2. In every other cycle mdr holds its value.
- R5: With fetch_req=1, imem_rd is 1 and imem_addr equals pc in the same cycle. The returned byte is loaded into mbr with the same two-edge latency as R4, and mbr_valid is 1 in the cycle it becomes usable.
- R6: Requests issued on consecutive cycles on either route each return their own data, in issue order, one cycle apart.
- R7: mbr_bus equals mbr with bits 31..8 copies of mbr bit 7 when sign_ext=1, and with bits 31..8 zero when sign_ext=0. It follows sign_ext in the same cycle.
- R8: When rd_req and wr_req are both 1, rdwr_clash is 1, dmem_rd and dmem_wr are both 0, memory is left unchanged and mdr is not loaded. Otherwise rdwr_clash is 0.
- R9: A data request and a fetch in the same cycle are both served, without either changing the other's timing or data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req | input | 1 | Request a word read at mar |
| wr_req | input | 1 | Request a word write of wr_data at mar |
| fetch_req | input | 1 | Request a byte fetch at pc |
| sign_ext | input | 1 | 1 widens mbr as signed on mbr_bus, 0 as unsigned |
| mar | input | 32 | Word address for the data route |
| wr_data | input | 32 | Word to be written |
| pc | input | 32 | Byte address for the fetch route |
| dmem_addr | output | 34 | Byte address to the data memory |
| dmem_rd | output | 1 | Read strobe to the data memory |
| dmem_wr | output | 1 | Write strobe to the data memory |
| dmem_wdata | output | 32 | Write data to the data memory |
| dmem_rdata | input | 32 | Read data, valid the cycle after dmem_rd |
| imem_addr | output | 32 | Byte address to the fetch port |
| imem_rd | output | 1 | Read strobe to the fetch port |
| imem_rdata | input | 8 | Fetched byte, valid the cycle after imem_rd |
| mdr | output | 32 | Memory data register |
| mdr_valid | output | 1 | mdr holds a freshly returned word this cycle |
| mbr | output | 8 | Fetch byte register |
| mbr_valid | output | 1 | mbr holds a freshly fetched byte this cycle |
| mbr_bus | output | 32 | mbr widened for the B bus |
| rdwr_clash | output | 1 | Read and write requested together |

## Verification
Isolated single reads, writes and fetches separated by idle cycles show the two-edge latency and the address conversion on their own. Back-to-back requests on one route, and requests on both routes in the same cycle, tell in-order pipelining apart from a controller that drops or reorders a result. Fetched bytes 0x80 and 0x7F are each read under both sign_ext settings, which separates the signed and unsigned widening at the sign boundary. A simultaneous read and write is followed by a read of the same word, which shows that nothing reached memory. A long random mix of all of these, with occasional clashes, follows the directed cases.

// File: rtl/mem_port_ctrl.sv
module mem_port_ctrl #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic              wr_req,
  input  logic              fetch_req,
  input  logic              sign_ext,
  input  logic [ADDR_W-1:0] mar,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] pc,
  output logic [ADDR_W+1:0] dmem_addr,
  output logic              dmem_rd,
  output logic              dmem_wr,
  output logic [DATA_W-1:0] dmem_wdata,
  input  logic [DATA_W-1:0] dmem_rdata,
  output logic [ADDR_W-1:0] imem_addr,
  output logic              imem_rd,
  input  logic [BYTE_W-1:0] imem_rdata,
  output logic [DATA_W-1:0] mdr,
  output logic              mdr_valid,
  output logic [BYTE_W-1:0] mbr,
  output logic              mbr_valid,
  output logic [DATA_W-1:0] mbr_bus,
  output logic              rdwr_clash
);
  localparam int EXT_W = DATA_W - BYTE_W;

  logic rd_pend, ft_pend;

  assign rdwr_clash = rd_req & wr_req;
  assign dmem_rd    = rd_req & ~wr_req;
  assign dmem_wr    = wr_req & ~rd_req;
  assign dmem_addr  = {mar, 2'b00};
  assign dmem_wdata = wr_data;
  assign imem_rd    = fetch_req;
  assign imem_addr  = pc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_pend   <= 1'b0;
      ft_pend   <= 1'b0;
      mdr       <= '0;
      mbr       <= '0;
      mdr_valid <= 1'b0;
      mbr_valid <= 1'b0;
    end else begin
      rd_pend   <= dmem_rd;
      ft_pend   <= imem_rd;
      mdr_valid <= rd_pend;
      mbr_valid <= ft_pend;
      if (rd_pend) mdr <= dmem_rdata;
      if (ft_pend) mbr <= imem_rdata;
    end
  end

  assign mbr_bus = sign_ext ? {{EXT_W{mbr[BYTE_W-1]}}, mbr} : {{EXT_W{1'b0}}, mbr};

  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_rd |=> ##1 mdr_valid); // R4
  AST_MDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !mdr_valid |-> $stable(mdr)); // R4
  AST_FETCH_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    imem_rd |=> ##1 mbr_valid); // R5
  AST_MBR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !mbr_valid |-> $stable(mbr)); // R5
  AST_CLASH_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    rdwr_clash && !$past(dmem_rd) |=> ##1 !mdr_valid); // R8
  AST_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    !sign_ext |-> mbr_bus[DATA_W-1:BYTE_W] == '0); // R7
endmodule

// File: tb/mem_port_ctrl_test.sv
module mem_port_ctrl_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, rd_req, wr_req, fetch_req, sign_ext;
  logic [31:0] mar, wr_data, pc, dmem_wdata, dmem_rdata, imem_addr, mdr, mbr_bus;
  logic [33:0] dmem_addr;
  logic dmem_rd, dmem_wr, imem_rd, mdr_valid, mbr_valid, rdwr_clash;
  logic [7:0] imem_rdata, mbr;

  mem_port_ctrl uut (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .wr_req(wr_req), .fetch_req(fetch_req),
    .sign_ext(sign_ext), .mar(mar), .wr_data(wr_data), .pc(pc),
    .dmem_addr(dmem_addr), .dmem_rd(dmem_rd), .dmem_wr(dmem_wr), .dmem_wdata(dmem_wdata),
    .dmem_rdata(dmem_rdata), .imem_addr(imem_addr), .imem_rd(imem_rd), .imem_rdata(imem_rdata),
    .mdr(mdr), .mdr_valid(mdr_valid), .mbr(mbr), .mbr_valid(mbr_valid),
    .mbr_bus(mbr_bus), .rdwr_clash(rdwr_clash)
  );

  logic [31:0] dm [0:63];

  function automatic logic [7:0] byte_at(input logic [31:0] a);
    logic [31:0] w;
    w = dm[a[7:2]];
    return 8'(w >> (8 * a[1:0]));
  endfunction

  function automatic logic [31:0] widen(input logic [7:0] b, input logic s);
    return s ? {{24{b[7]}}, b} : {24'h0, b};
  endfunction

  always @(posedge clk) begin
    if (dmem_rd) dmem_rdata <= dm[dmem_addr[7:2]];
    if (dmem_wr) dm[dmem_addr[7:2]] <= dmem_wdata;
    if (imem_rd) imem_rdata <= byte_at(imem_addr);
  end

  int errs = 0, checks = 0;

  task automatic chk(input string tg, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tg, act, exp);
    end
  endtask

  logic dv_now, dv1, iv_now, iv1;
  logic [31:0] dd_now, dd1;
  logic [7:0] ib_now, ib1;

  task automatic step(input string tg, input logic rd, input logic wr, input logic fe,
                      input logic ext, input logic [31:0] a, input logic [31:0] wd,
                      input logic [31:0] p);
    logic nd_v;
    logic [31:0] nd;
    logic [7:0] ni;
    chk({tg, " R4 mdr_valid"}, 64'(mdr_valid), 64'(dv_now));
    chk({tg, " R4 mdr"}, 64'(mdr), 64'(dd_now));
    chk({tg, " R5 mbr_valid"}, 64'(mbr_valid), 64'(iv_now));
    chk({tg, " R5 mbr"}, 64'(mbr), 64'(ib_now));
    rd_req = rd; wr_req = wr; fetch_req = fe; sign_ext = ext;
    mar = a; wr_data = wd; pc = p;
    #1;
    chk({tg, " R8 rdwr_clash"}, 64'(rdwr_clash), 64'(rd & wr));
    chk({tg, " R2 dmem_rd"}, 64'(dmem_rd), 64'(rd & ~wr));
    chk({tg, " R3 dmem_wr"}, 64'(dmem_wr), 64'(wr & ~rd));
    if (rd | wr) chk({tg, " R2 dmem_addr"}, 64'(dmem_addr), 64'(a) * 64'd4);
    if (wr & ~rd) chk({tg, " R3 dmem_wdata"}, 64'(dmem_wdata), 64'(wd));
    chk({tg, " R5 imem_rd"}, 64'(imem_rd), 64'(fe));
    if (fe) chk({tg, " R5 imem_addr"}, 64'(imem_addr), 64'(p));
    chk({tg, " R7 mbr_bus"}, 64'(mbr_bus), 64'(widen(ib_now, ext)));
    nd_v = rd & ~wr;
    nd = dm[a[5:0]];
    ni = byte_at(p);
    @(posedge clk);
    if (dv1) dd_now = dd1;
    dv_now = dv1; dv1 = nd_v; dd1 = nd;
    if (iv1) ib_now = ib1;
    iv_now = iv1; iv1 = fe; ib1 = ni;
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd1234);
    for (int i = 0; i < 64; i++) dm[i] = (32'(i) * 32'h0103_0507) ^ 32'h8C4A_2E19;
    rst_n = 1'b0; rd_req = 0; wr_req = 0; fetch_req = 0; sign_ext = 0;
    mar = 0; wr_data = 0; pc = 0;
    dv_now = 0; dv1 = 0; iv_now = 0; iv1 = 0; dd_now = 0; dd1 = 0; ib_now = 0; ib1 = 0;
    repeat (3) @(negedge clk);
    chk("R1 mdr", 64'(mdr), 64'h0);
    chk("R1 mdr_valid", 64'(mdr_valid), 64'h0);
    chk("R1 mbr", 64'(mbr), 64'h0);
    chk("R1 mbr_valid", 64'(mbr_valid), 64'h0);
    sign_ext = 1'b1; #1;
    chk("R1 mbr_bus", 64'(mbr_bus), 64'h0);
    @(negedge clk);
    rst_n = 1'b1;
    step("R1", 0, 0, 0, 0, 0, 0, 0);
    // R3 write, R2/R4 read back after idle
    step("R3", 0, 1, 0, 0, 32'h4000_0003, 32'h1234_7F80, 0);
    step("R3", 0, 0, 0, 0, 0, 0, 0);
    step("R2", 1, 0, 0, 0, 32'h4000_0003, 0, 0);
    repeat (3) step("R4", 0, 0, 0, 0, 0, 0, 0);
    // R6 back-to-back reads and fetches, R9 both routes together
    step("R6", 1, 0, 1, 1, 5, 0, 32'd12);
    step("R6", 1, 0, 1, 1, 6, 0, 32'd13);
    step("R9", 1, 0, 1, 0, 7, 0, 32'd14);
    step("R9", 0, 1, 1, 0, 8, 32'hDEAD_BEEF, 32'd15);
    // R7 both widths for 0x80 and 0x7F
    step("R7", 0, 0, 1, 1, 0, 0, 32'd12);
    step("R7", 0, 0, 0, 1, 0, 0, 0);
    step("R7", 0, 0, 0, 1, 0, 0, 0);
    step("R7", 0, 0, 0, 0, 0, 0, 0);
    step("R7", 0, 0, 1, 0, 0, 0, 32'd13);
    step("R7", 0, 0, 0, 1, 0, 0, 0);
    step("R7", 0, 0, 0, 1, 0, 0, 0);
    step("R7", 0, 0, 0, 0, 0, 0, 0);
    // R8 clash leaves memory and mdr alone
    step("R8", 1, 1, 0, 0, 9, 32'h5555_AAAA, 0);
    step("R8", 0, 0, 0, 0, 0, 0, 0);
    step("R8", 1, 0, 0, 0, 9, 0, 0);
    repeat (3) step("R8", 0, 0, 0, 0, 0, 0, 0);
    chk("R8 memory untouched", 64'(mdr), 64'((32'd9 * 32'h0103_0507) ^ 32'h8C4A_2E19));
    // random mix
    for (int n = 0; n < 600; n++) begin
      logic [31:0] r;
      logic rd, wr;
      r = $urandom;
      rd = r[0]; wr = r[1] & (~r[0] | (r[4:2] == 3'd0));
      step("R9 random", rd, wr, r[5], r[6], {r[31:28], 22'h0, r[12:7]}, $urandom, {24'h0, r[20:13]});
    end
    repeat (3) step("R6 drain", 0, 0, 0, 0, 0, 0, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule